// File: doc/BRIEF.md
# Three-Channel Prescaled Event Timer

This block counts timed events on three independent channels. Each channel owns an 8-bit divider: it spends a programmable number of enabled ticks counting down, then records one event in a 4-bit event counter and starts the next period from the divider value. Two of the channels advance on a slow tick strobe. The third advances on a fast strobe that runs at eight times the slow rate. Both strobes are one-cycle enables that the surrounding logic derives from the system clock.

Software sets up the channels through a byte-wide write port and collects events through a read port. The write port takes a channel-enable mask and the three divider values. Reading an event counter returns its value and empties it in the same access, so each event is reported exactly once.

Top module: `evt_timer3`

## Requirements
- R1: After reset, all enables, dividers, remaining counts and event counters are zero, so each event counter reads 0.
- R2: Address 0x0 holds the enable mask: bit 0 enables channel 0, bit 1 channel 1, bit 2 channel 2. A disabled channel ignores ticks, so its event counter does not change.
- R3: Channels 0 and 1 advance only on `tick_slow`. Channel 2 advances only on `tick_fast`.
- R4: On each enabled tick the remaining count decrements. When it reaches zero, the event counter increments and the remaining count reloads from the divider.
- R5: A write to a divider register (0xA, 0xB or 0xC for channels 0, 1 and 2) always stores the value. It also loads the remaining count, but only when that count is zero.
- R6: A divider value of 0 gives a period of 256 ticks.
- R7: A read of 0xD, 0xE or 0xF returns the 4-bit event counter of channel 0, 1 or 2 and clears it on that clock edge. A read of any other address, and the idle port, return 0.
- R8: An event counter wraps from 15 to 0.
- R9: If a clearing read and an increment fall on the same edge, the read returns the old value and the counter ends at 1.
- R10: When a channel goes from disabled to enabled, its event counter clears and its remaining count reloads from its divider. A tick in that cycle is ignored.
- R11: If a divider write loads a zero remaining count in the same cycle as a tick, the written value is loaded and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | One-cycle strobe for channels 0 and 1 |
| tick_fast | input | 1 | One-cycle strobe for channel 2, eight times the slow rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset in the 16-byte window |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a counter read clears that counter |
| rd_addr | input | 4 | Read offset in the 16-byte window |
| rd_data | output | 4 | Combinational read data |

## Verification
A wrong remaining count shows up only as an event arriving early or late. This can take up to 256 ticks of the channel's strobe, so the bench reads every counter often and compares it with a model of each channel's period. A failed clear or a failed enable reload shows up at the next read of that counter as a stale, non-zero value. An error in the same-edge orderings (a read meeting an increment, a divider write meeting a tick) differs by one in the count, and that difference stays visible until the counter is next read.

// File: rtl/evt_timer3.sv
module evt_timer3 #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4,
  parameter int AW    = 4,
  parameter logic [AW-1:0] CTL_ADDR = 4'h0,
  parameter logic [AW-1:0] DIV_BASE = 4'hA,
  parameter logic [AW-1:0] CNT_BASE = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NCH = 3;

  logic [NCH-1:0]            en_q;
  logic [NCH-1:0][DIV_W-1:0] div_q;
  logic [NCH-1:0][DIV_W-1:0] rem_q;
  logic [NCH-1:0][CNT_W-1:0] cnt_q;

  wire ctl_wr = wr_en && (wr_addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      en_q <= '0;
    else if (ctl_wr) en_q <= wr_data[NCH-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    wire             tick   = ((ch == NCH-1) ? tick_fast : tick_slow) && en_q[ch];
    wire             div_wr = wr_en && (wr_addr == DIV_BASE + AW'(ch));
    wire             rise   = ctl_wr && wr_data[ch] && !en_q[ch];
    wire             rd_hit = rd_en && (rd_addr == CNT_BASE + AW'(ch));
    wire [DIV_W-1:0] dec    = rem_q[ch] - 1'b1;
    wire             load   = div_wr && (rem_q[ch] == '0);
    wire             expire = tick && !load && (dec == '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        div_q[ch] <= '0;
        rem_q[ch] <= '0;
        cnt_q[ch] <= '0;
      end else begin
        if (div_wr) div_q[ch] <= wr_data;
        if (rise)      rem_q[ch] <= div_q[ch];
        else if (load) rem_q[ch] <= wr_data;
        else if (tick) rem_q[ch] <= expire ? div_q[ch] : dec;
        if (rise) cnt_q[ch] <= '0;
        else      cnt_q[ch] <= (rd_hit ? '0 : cnt_q[ch]) + CNT_W'(expire);
      end
  end

  always_comb begin
    rd_data = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (rd_en && rd_addr == CNT_BASE + AW'(ch)) rd_data = cnt_q[ch];
  end
endmodule

module evt_timer3_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_slow,
  input logic            tick_fast,
  input logic            wr_en,
  input logic [3:0]      wr_addr,
  input logic [7:0]      wr_data,
  input logic            rd_en,
  input logic [3:0]      rd_addr,
  input logic [2:0]      en_q,
  input logic [2:0][7:0] div_q,
  input logic [2:0][7:0] rem_q,
  input logic [2:0][3:0] cnt_q
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] && !wr_en) |=> $stable(rem_q[0]));

  a_r3_fast_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[2] && !tick_fast && !wr_en) |=> $stable(rem_q[2]));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[0] && tick_slow && rem_q[0] == 8'd1 && !wr_en) |=> (rem_q[0] == $past(div_q[0])));

  a_r5_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'hB && rem_q[1] != 8'd0 && !(en_q[1] && tick_slow))
    |=> (rem_q[1] == $past(rem_q[1]) && div_q[1] == $past(wr_data)));

  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'hD && !(en_q[0] && tick_slow && rem_q[0] == 8'd1))
    |=> (cnt_q[0] == 4'd0));

  a_r9_read_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'hD && en_q[0] && tick_slow && rem_q[0] == 8'd1 && !wr_en)
    |=> (cnt_q[0] == 4'd1));

  a_r10_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h0 && wr_data[2] && !en_q[2])
    |=> (cnt_q[2] == 4'd0 && rem_q[2] == $past(div_q[2])));
endmodule

bind evt_timer3 evt_timer3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr),
  .en_q(en_q), .div_q(div_q), .rem_q(rem_q), .cnt_q(cnt_q)
);

// File: tb/evt_timer3_tb.sv
module evt_timer3_tb_top;
  logic clk = 0, rst_n = 0;
  logic tick_slow = 0, tick_fast = 0, wr_en = 0, rd_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [2:0]      men;
  logic [2:0][7:0] mdiv, mrem;
  logic [2:0][3:0] mcnt;

  always #10 clk = ~clk;

  evt_timer3 dut_i (.*);

  function automatic logic [3:0] exp_read(logic en, logic [3:0] a);
    if (en && a >= 4'hD) return mcnt[a - 4'hD];
    return 4'd0;
  endfunction

  task automatic model_update(logic ts, logic tf, logic we, logic [3:0] wa, logic [7:0] wd,
                              logic re, logic [3:0] ra);
    logic [2:0]      nen  = men;
    logic [2:0][7:0] ndiv = mdiv, nrem = mrem;
    logic [2:0][3:0] ncnt = mcnt;
    for (int i = 0; i < 3; i++) begin
      logic tk   = ((i == 2) ? tf : ts) && men[i];
      logic dw   = we && wa == 4'hA + 4'(i);
      logic rise = we && wa == 4'h0 && wd[i] && !men[i];
      logic rh   = re && ra == 4'hD + 4'(i);
      logic ld   = dw && mrem[i] == 0;
      logic ex   = tk && !ld && mrem[i] == 8'd1;
      if (dw) ndiv[i] = wd;
      if (rise)    nrem[i] = mdiv[i];
      else if (ld) nrem[i] = wd;
      else if (tk) nrem[i] = ex ? mdiv[i] : mrem[i] - 8'd1;
      if (rise) ncnt[i] = 0;
      else      ncnt[i] = (rh ? 4'd0 : mcnt[i]) + {3'd0, ex};
    end
    if (we && wa == 4'h0) nen = wd[2:0];
    men = nen; mdiv = ndiv; mrem = nrem; mcnt = ncnt;
  endtask

  task automatic step(logic ts, logic tf, logic we, logic [3:0] wa, logic [7:0] wd,
                      logic re, logic [3:0] ra, string tag);
    @(negedge clk);
    tick_slow = ts; tick_fast = tf; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    #1;
    if (re) begin
      n_cmp++;
      if (rd_data !== exp_read(re, ra)) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, ra, rd_data, exp_read(re, ra));
      end
    end
    @(posedge clk);
    model_update(ts, tf, we, wa, wd, re, ra);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    men = 0; mdiv = 0; mrem = 0; mcnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 4'hD + 4'(i), "R1");
    // R2 disabled channel ignores ticks
    step(0, 0, 1, 4'hA, 8'd2, 0, 0, "R5");
    for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R2");
    // R10 + R4 channel 0 divider 2
    step(0, 0, 1, 4'h0, 8'h01, 0, 0, "R10");
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R4");
    // R3 channel 2 only on fast tick
    step(0, 0, 1, 4'hC, 8'd3, 0, 0, "R5");
    step(0, 0, 1, 4'h0, 8'h05, 0, 0, "R10");
    for (int k = 0; k < 9; k++) step(1, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 4'hF, "R3");
    for (int k = 0; k < 7; k++) step(0, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 4'hF, "R3");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R3");
    // R6 divider 0 on channel 1 -> 256 ticks
    step(0, 0, 1, 4'hB, 8'd0, 0, 0, "R6");
    step(0, 0, 1, 4'h0, 8'h07, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 4'hE, "R6");
    for (int k = 0; k < 255; k++) step(1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 4'hE, "R6");
    step(1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 4'hE, "R6");
    // R5 busy write keeps remaining count
    step(0, 0, 1, 4'hA, 8'd1, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R5");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 1, 4'hD, "R5");
    // R8 wrap with divider 1 on channel 0
    for (int k = 0; k < 17; k++) step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R8");
    // R9 read coinciding with increment
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 1, 4'hD, "R9");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R9");
    // R7 non-counter address reads zero
    step(0, 0, 0, 0, 0, 1, 4'hA, "R7");
    step(0, 0, 0, 0, 0, 1, 4'h0, "R7");
    // R11 load with tick on disabled-then-enabled channel 0 at zero count
    step(0, 0, 1, 4'h0, 8'h00, 0, 0, "R11");
    step(0, 0, 1, 4'hA, 8'd0, 0, 0, "R11");
    step(0, 0, 1, 4'h0, 8'h01, 0, 0, "R11");
    step(1, 0, 1, 4'hA, 8'd3, 0, 0, "R11");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 1, 4'hD, "R11");
    // random phase
    void'($urandom(32'h5EED));
    for (int k = 0; k < 6000; k++) begin
      logic [3:0] wa, ra;
      logic [7:0] wd;
      int pick = $urandom_range(0, 3);
      wa = (pick == 0) ? 4'h0 : 4'h9 + 4'(pick);
      wd = (pick == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom_range(0, 6));
      ra = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'hD + 4'($urandom_range(0, 2));
      step($urandom_range(0, 1) == 0, $urandom_range(0, 1) == 0,
           $urandom_range(0, 40) == 0, wa, wd,
           $urandom_range(0, 5) == 0, ra, "R4/R7/R9 random");
    end
    idle(2);
    finish_run();
  end
endmodule